// File: doc/BRIEF.md
# Memory Retention Test Sequencer

This block is a self-test sequencer for one single-port synchronous RAM. It checks that the RAM holds its data. A start pulse launches the test, and the test runs in two phases. In each phase the sequencer fills the RAM with a checkerboard word and then goes quiet. It raises a waiting flag and issues no memory traffic until an outside agent has let the retention time pass and pulses resume. It then reads every word back and compares it with the word it wrote.

The second phase repeats the fill, the pause and the readback with the complementary checkerboard. The first mismatch is captured together with its address and phase, and the test still runs to the end. Done then rises and stays high, with the pass/fail result, until the next start.

The sequencer does not time the retention interval. That time belongs entirely to whoever drives resume, for example a tester or a slow on-chip timer.

Top module: `ret_bist`

## Requirements
- R1: After reset, `mem_en_o`, `mem_we_o`, `waiting_o`, `done_o`, `fail_o`, `fail_phase_o` and `fail_addr_o` are all zero.
- R2: A `start_i` pulse sampled while idle or done makes the block write every address once, in ascending order from 0, one word per cycle starting the next cycle. The write word in phase 0 repeats the bit pair 01 from bit 0 upward (0x55 for 8 bits) at even addresses and its complement (0xAA) at odd addresses.
- R3: After the last write, `waiting_o` is high and `mem_en_o` stays low for as long as `waiting_o` stays high. `waiting_o` stays high until `resume_i` is sampled high.
- R4: `waiting_o` drops in the cycle after `resume_i` is sampled high. In that same cycle the read pass starts, reading every address once in ascending order with `mem_we_o` low.
- R5: A `resume_i` pulse that arrives while `waiting_o` is low has no effect. A later wait still holds until a new resume arrives.
- R6: Read data is taken one cycle after the read is issued and compared with the word written to that address. The first mismatch in a test sets `fail_o` and captures `fail_addr_o` and `fail_phase_o` (0 for the first phase, 1 for the second). Later mismatches change nothing, and the test continues to the end.
- R7: After the first readback, a second phase writes the inverted words (0xAA at even addresses, 0x55 at odd ones), waits for a fresh resume and reads back as in R3 and R4.
- R8: After the second readback, `done_o` rises and holds, with the fail outputs unchanged, until the next start. The next start clears all fail outputs.
- R9: `start_i` during a running test is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse |
| resume_i | input | 1 | End of retention wait |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid one cycle after a read |
| waiting_o | output | 1 | Sequencer paused for retention |
| done_o | output | 1 | Both phases finished |
| fail_o | output | 1 | A mismatch was seen |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_phase_o | output | 1 | Phase of the first mismatch |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the RAM stays silent while the sequencer is waiting;
- the wait is held until resume, and is released exactly one cycle after it;
- done holds until a start, and a start from done issues a write to address 0;
- a captured failure stays put, and the first compare miss raises fail.

Only the bench scenarios can show the rest. The address order and checkerboard contents of each pass are checked against the bench's own word function. So is the choice of the first failing address and phase when bits are corrupted during a pause. The scenarios also show that resume or start pulses sent at the wrong time leave the result untouched.

// File: rtl/ret_bist_pkg.sv
package ret_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READ  = 3'd3,
    ST_DRAIN = 3'd4,
    ST_DONE  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/ret_bist_addr_gen.sv
module ret_bist_addr_gen #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;  // wraps to 0 after the top address
  end

  assign addr_o = cnt_q;
  assign last_o = (cnt_q == TOP);
endmodule

// File: rtl/ret_bist_pat.sv
module ret_bist_pat #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              phase_i,
  input  logic              odd_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned PAIRS = DATA_W / 2;

  // Base word: bit pair 01 repeated from bit 0 upward.
  function automatic logic [DATA_W-1:0] chk_word(input logic ph, input logic odd);
    logic [DATA_W-1:0] base;
    base = {PAIRS{2'b01}};
    return base ^ {DATA_W{ph ^ odd}};
  endfunction

  assign word_o = chk_word(phase_i, odd_i);
endmodule

// File: rtl/ret_bist_cmp.sv
module ret_bist_cmp #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              phase_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              miss_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              fail_phase_o
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic              phase_q;
  logic [DATA_W-1:0] exp_word;

  // Delay the read request by one cycle to line up with the RAM latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      vld_q   <= issue_i;
      addr_q  <= addr_i;
      phase_q <= phase_i;
    end
  end

  ret_bist_pat #(.DATA_W(DATA_W)) exp_pat_i (
    .phase_i (phase_q),
    .odd_i   (addr_q[0]),
    .word_o  (exp_word)
  );

  assign miss_o = vld_q && (rdata_i != exp_word);

  // Capture the first mismatch only; a new start clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_phase_o <= 1'b0;
    end else if (clear_i) begin
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_phase_o <= 1'b0;
    end else if (miss_o && !fail_o) begin
      fail_o       <= 1'b1;
      fail_addr_o  <= addr_q;
      fail_phase_o <= phase_q;
    end
  end
endmodule

// File: rtl/ret_bist.sv
module ret_bist
  import ret_bist_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              resume_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              waiting_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic              fail_phase_o
);
  seq_state_t        st_q, st_d;
  logic              phase_q;
  logic [ADDR_W-1:0] addr;
  logic              addr_last;

  // Named internal events.
  logic launch, wr_last, rd_last, resume_ok, phase_flip, cmp_miss;

  assign launch     = start_i && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign wr_last    = (st_q == ST_WRITE) && addr_last;
  assign rd_last    = (st_q == ST_READ) && addr_last;
  assign resume_ok  = (st_q == ST_WAIT) && resume_i;
  assign phase_flip = (st_q == ST_DRAIN) && !phase_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (launch)    st_d = ST_WRITE;
      ST_WRITE:         if (wr_last)   st_d = ST_WAIT;
      ST_WAIT:          if (resume_ok) st_d = ST_READ;
      ST_READ:          if (rd_last)   st_d = ST_DRAIN;
      ST_DRAIN:         st_d = phase_q ? ST_DONE : ST_WRITE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (launch)          phase_q <= 1'b0;
      else if (phase_flip) phase_q <= 1'b1;
    end
  end

  ret_bist_addr_gen #(.ADDR_W(ADDR_W)) addr_gen_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (launch),
    .inc_i  ((st_q == ST_WRITE) || (st_q == ST_READ)),
    .addr_o (addr),
    .last_o (addr_last)
  );

  ret_bist_pat #(.DATA_W(DATA_W)) wr_pat_i (
    .phase_i (phase_q),
    .odd_i   (addr[0]),
    .word_o  (mem_wdata_o)
  );

  ret_bist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (launch),
    .issue_i      (st_q == ST_READ),
    .addr_i       (addr),
    .phase_i      (phase_q),
    .rdata_i      (mem_rdata_i),
    .miss_o       (cmp_miss),
    .fail_o       (fail_o),
    .fail_addr_o  (fail_addr_o),
    .fail_phase_o (fail_phase_o)
  );

  assign mem_en_o   = (st_q == ST_WRITE) || (st_q == ST_READ);
  assign mem_we_o   = (st_q == ST_WRITE);
  assign mem_addr_o = addr;
  assign waiting_o  = (st_q == ST_WAIT);
  assign done_o     = (st_q == ST_DONE);
endmodule

// File: rtl/ret_bist_chk.sv
module ret_bist_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              resume_i,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              waiting_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic              fail_phase_o,
  input logic              cmp_miss
);
  p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_o |-> !mem_en_o);

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_o && !resume_i |=> waiting_o);

  p_wait_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_o && resume_i |=> !waiting_o && mem_en_o && !mem_we_o);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && start_i |=> mem_en_o && mem_we_o && (mem_addr_o == '0));

  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o && !start_i |=> fail_o && $stable(fail_addr_o) && $stable(fail_phase_o));

  p_first_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_miss && !fail_o |=> fail_o);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_en_o && !waiting_o);
endmodule

bind ret_bist ret_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .resume_i     (resume_i),
  .mem_en_o     (mem_en_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .waiting_o    (waiting_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .fail_addr_o  (fail_addr_o),
  .fail_phase_o (fail_phase_o),
  .cmp_miss     (cmp_miss)
);

// File: tb/ret_bist_tb_top.sv
module ret_bist_tb_top;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          resume_i = 1'b0;
  logic          mem_en_o, mem_we_o, waiting_o, done_o, fail_o, fail_phase_o;
  logic [AW-1:0] mem_addr_o, fail_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;

  logic [DW-1:0] ram [DEPTH];

  int errs = 0, checks = 0;
  int wr_total = 0, rd_total = 0, mon_err = 0;

  always #2.5 clk = ~clk;

  ret_bist #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .waiting_o(waiting_o), .done_o(done_o), .fail_o(fail_o),
    .fail_addr_o(fail_addr_o), .fail_phase_o(fail_phase_o)
  );

  // RAM model: one-cycle read latency.
  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= ram[mem_addr_o];
    end
  end

  // Expected checkerboard word, built bit by bit.
  function automatic logic [DW-1:0] exp_word(input int ph, input int a);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = ((i % 2) == 0) ^ ((a % 2) == 1) ^ (ph == 1);
    return w;
  endfunction

  // Monitor of the memory traffic (R2, R3, R4, R7).
  always @(negedge clk) begin
    if (rst_n && mem_en_o) begin
      if (waiting_o) mon_err++;
      if (mem_we_o) begin
        if (mem_addr_o != AW'(wr_total % DEPTH) ||
            mem_wdata_o != exp_word(wr_total / DEPTH, wr_total % DEPTH)) mon_err++;
        wr_total++;
      end else begin
        if (mem_addr_o != AW'(rd_total % DEPTH)) mon_err++;
        if (rd_total >= (wr_total == DEPTH ? DEPTH : 2 * DEPTH)) mon_err++;
        rd_total++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_for(input int sel, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if ((sel == 0 && waiting_o) || (sel == 1 && done_o)) begin ok = 1'b1; break; end
    end
    if (!ok) check(1'b0, "R3", "timeout waiting for event", sel, -1);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  // Full test: corruption masks per phase; optional stray resume/start pulses.
  task automatic run_test(input logic [DW-1:0] c0 [DEPTH], input logic [DW-1:0] c1 [DEPTH],
                          input bit stray_resume, input bit stray_start);
    bit ok, exp_fail, exp_ph;
    int exp_addr, k;
    wr_total = 0; rd_total = 0; mon_err = 0;
    exp_fail = 1'b0; exp_ph = 1'b0; exp_addr = 0;
    for (int a = DEPTH - 1; a >= 0; a--) if (c1[a] != 0) begin exp_fail = 1; exp_ph = 1; exp_addr = a; end
    for (int a = DEPTH - 1; a >= 0; a--) if (c0[a] != 0) begin exp_fail = 1; exp_ph = 0; exp_addr = a; end
    @(negedge clk);
    pulse_start();
    if (stray_resume) begin
      @(negedge clk); resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
    end
    for (int ph = 0; ph < 2; ph++) begin
      wait_for(0, ok);
      if (!ok) return;
      check(wr_total == DEPTH * (ph + 1), ph ? "R7" : "R2", "writes before wait",
            wr_total, DEPTH * (ph + 1));
      k = 2 + int'($urandom_range(0, 20));
      if (stray_start && ph == 0) begin start_i = 1'b1; @(negedge clk); start_i = 1'b0; k--; end
      repeat (k) @(negedge clk);
      check(waiting_o == 1'b1, stray_resume ? "R5" : "R3", "wait held without resume",
            waiting_o, 1);
      for (int a = 0; a < DEPTH; a++) ram[a] = ram[a] ^ (ph ? c1[a] : c0[a]);
      resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
      check(waiting_o == 1'b0 && mem_en_o && !mem_we_o, "R4",
            "wait release one cycle after resume", waiting_o, 0);
    end
    wait_for(1, ok);
    if (!ok) return;
    check(fail_o == exp_fail, "R6", "fail flag", fail_o, exp_fail);
    if (exp_fail) begin
      check(fail_addr_o == AW'(exp_addr), "R6", "first fail address", fail_addr_o, exp_addr);
      check(fail_phase_o == exp_ph, "R6", "first fail phase", fail_phase_o, exp_ph);
    end
    check(wr_total == 2 * DEPTH && rd_total == 2 * DEPTH, stray_start ? "R9" : "R7",
          "total accesses", wr_total + rd_total, 4 * DEPTH);
    check(mon_err == 0, "R2", "order/data of accesses", mon_err, 0);
    resume_i = 1'b1;
    repeat (1 + int'($urandom_range(0, 8))) @(negedge clk);
    resume_i = 1'b0; @(negedge clk);
    check(done_o && !mem_en_o && fail_o == exp_fail, "R8", "done held, resume ignored",
          done_o, 1);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R8", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] z [DEPTH];
    logic [DW-1:0] f0 [DEPTH];
    logic [DW-1:0] f1 [DEPTH];
    void'($urandom(32'd1234));
    for (int a = 0; a < DEPTH; a++) begin z[a] = '0; ram[a] = '0; end
    repeat (3) @(negedge clk);
    check(!mem_en_o && !mem_we_o && !waiting_o && !done_o && !fail_o &&
          !fail_phase_o && fail_addr_o == '0, "R1", "reset outputs", mem_en_o, 0);
    rst_n = 1'b1;
    // Resume while idle is ignored (R5).
    resume_i = 1'b1; repeat (3) @(negedge clk); resume_i = 1'b0;
    check(!mem_en_o && !waiting_o && !done_o, "R5", "idle resume ignored", mem_en_o, 0);

    // Clean memory with a stray resume during the write pass.
    run_test(z, z, 1'b1, 1'b0);
    // Directed: address 0 and others corrupted in phase 0, plus phase 1 faults.
    f0 = z; f1 = z; f0[0] = 8'h01; f0[9] = 8'h80; f1[3] = 8'hFF;
    run_test(f0, f1, 1'b0, 1'b0);
    check(fail_addr_o == 0, "R6", "fail address zero", fail_addr_o, 0);
    // Directed: only the last address in phase 1, with a stray start.
    f0 = z; f1 = z; f1[DEPTH-1] = 8'h10;
    run_test(f0, f1, 1'b0, 1'b1);
    // Clean again: the previous fail must be cleared by start (R8).
    run_test(z, z, 1'b0, 1'b0);
    check(fail_o == 0, "R8", "fail cleared by new start", fail_o, 0);
    // Random corruption patterns.
    for (int t = 0; t < 8; t++) begin
      for (int a = 0; a < DEPTH; a++) begin
        f0[a] = ($urandom_range(0, 15) == 0) ? DW'($urandom_range(1, 255)) : '0;
        f1[a] = ($urandom_range(0, 9) == 0)  ? DW'($urandom_range(1, 255)) : '0;
      end
      run_test(f0, f1, t[0], t[1]);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule